// File: doc/BRIEF.md
# eMMC Alternative Boot Sequencer

This block runs the alternative boot phase of an eMMC card interface in hardware. Software gives it a start strobe, a flag that says whether the card will send a boot acknowledge, and the total boot image size in bytes. The sequencer first holds the command line released for the initialization clocks. It then shifts out the boot-initiation command frame. If an acknowledge is expected, it watches DAT0 for one. It then waits for the first data start bit and counts received 512-byte blocks until the image is complete. Two watchdogs guard the wait for the acknowledge and the wait for data after it.

The state machine has six states:
- `S_IDLE`: takes `S_IDLE -> S_INIT` on an accepted start.
- `S_INIT`: drives the initialization clocks and takes `S_INIT -> S_CMD` when they are done.
- `S_CMD`: shifts the frame out. After the last bit it takes `S_CMD -> S_ACKW` in acknowledge mode and `S_CMD -> S_DATW` otherwise.
- `S_ACKW`: leaves by `S_ACKW -> S_DATW` when a valid acknowledge arrives, and by `S_ACKW -> S_IDLE` when the acknowledge watchdog expires.
- `S_DATW`: leaves by `S_DATW -> S_RECV` when a data start bit arrives, and by `S_DATW -> S_IDLE` when the data watchdog expires.
- `S_RECV`: takes `S_RECV -> S_IDLE` when the final block arrives.

Each event sets a sticky flag in a six-bit status word that software clears by writing ones. The interrupt line is the OR of the flags. Storage of the data, the clock divider and the DMA engine sit outside this block: a neighbouring receiver signals each complete block on `blk_rcvd`.

Top module: `emmc_boot_seq`

## Requirements
- R1: A start pulse is accepted only in `S_IDLE`, and only when `byte_count` is nonzero with its low 17 bits zero (a whole multiple of 131072 bytes). Any other start leaves the block idle with `busy` low.
- R2: After an accepted start, `cmd_oe` stays low and `cmd_out` stays high for exactly INIT_CYC clocks (default 74) with `busy` high, before the first frame bit.
- R3: The command frame is 48 bits, sent MSB first on `cmd_out` with `cmd_oe` high for exactly those 48 clocks. In order, the bits are: start bit 0, transmission bit 1, index 000000, argument 0xFFFFFFFA, CRC7, and end bit 1. The CRC7 uses polynomial x^7+x^3+1 and a zero start value, and covers the first 40 bits.
- R4: After the last frame bit, status bit 0 (command done) is set. When `expect_ack` was low at start, no acknowledge is looked for and no watchdog runs: the block waits for data indefinitely, and status bits 1 and 3 stay clear.
- R5: In acknowledge mode, the acknowledge is valid when DAT0 shows a 0 start bit followed by the three bits 0, 1, 0. A valid acknowledge sets status bit 1. Any other three bits after a start bit are not an acknowledge.
- R6: In acknowledge mode, suppose no valid acknowledge arrives within ACK_TMO_CYC clocks. The clocks are counted from the first frame bit, taken as cycle 0. Then the block sets status bit 3 and leaves status bit 5 clear. It drops `rx_armed` and pulses `done` in cycle ACK_TMO_CYC+1.
- R7: After an acknowledge, DAT0 must go low within DATA_TMO_CYC clocks. The clocks are counted from the first cycle in which status bit 1 is visible. If it does not, the block sets status bit 4 and pulses `done` in cycle DATA_TMO_CYC+1.
- R8: DAT0 low while waiting for data sets status bit 2 and starts the block count.
- R9: `blk_rcvd` pulses count only after the data start. In the cycle after the pulse numbered `byte_count`/512, status bit 5 is set, `done` is high and `busy` is low.
- R10: Each status bit stays set until a 1 is written to its bit of `clr`. A set event in the same cycle wins over the clear.
- R11: `irq` is high exactly when any status bit is set.
- R12: A start pulse while `busy` is high has no effect on the running boot, its mode or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the card clock runs at this rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Boot start strobe |
| expect_ack | input | 1 | 1: a boot acknowledge is expected |
| byte_count | input | BCW | Total boot image size in bytes |
| clr | input | 6 | Write-1-to-clear mask for the status bits |
| dat0 | input | 1 | Card DAT0 line |
| blk_rcvd | input | 1 | One-cycle pulse per received 512-byte block |
| cmd_out | output | 1 | Command line data |
| cmd_oe | output | 1 | Command line drive enable |
| rx_armed | output | 1 | Receive path open (waiting for ack/data or receiving) |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle pulse on return to idle |
| status | output | 6 | Sticky flags: 0 cmd done, 1 ack, 2 data start, 3 ack timeout, 4 data timeout, 5 rx complete |
| irq | output | 1 | OR of the status bits |

## Verification
The hardest situation to reach is an acknowledge-looking start bit on DAT0 that carries the wrong three bits. The detector must drop it, and the acknowledge watchdog must still fire on its exact cycle while a stray start strobe arrives in the middle of the wait. The stimulus gets there by driving DAT0 bit by bit on falling edges, beginning right after the captured frame ends. A second directed case is the unbounded data wait in no-acknowledge mode, which is held longer than both watchdog limits. The randomized boots then vary the mode, the gaps and the image size, and inject a stray block pulse before the data start.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_CMD,
        S_ACKW,
        S_DATW,
        S_RECV
    } boot_state_t;

    localparam int STAT_W      = 6;
    localparam int ST_CMD_DONE = 0;
    localparam int ST_ACK      = 1;
    localparam int ST_DSTART   = 2;
    localparam int ST_ACK_TMO  = 3;
    localparam int ST_DAT_TMO  = 4;
    localparam int ST_RX_DONE  = 5;

    localparam int FRAME_LEN   = 48;
    localparam int HDR_LEN     = 40;
    localparam int CRC_W       = 7;
    localparam int BLK_LOG2    = 9;
    localparam int GRAN_LOG2   = 17;

    localparam logic [5:0]  BOOT_IDX = 6'd0;
    localparam logic [31:0] BOOT_ARG = 32'hFFFF_FFFA;
    localparam logic [HDR_LEN-1:0] BOOT_HDR = {1'b0, 1'b1, BOOT_IDX, BOOT_ARG};
    localparam logic [CRC_W-1:0]   CRC_POLY = 7'h09;
    localparam logic [2:0]         ACK_PAT  = 3'b010;

endpackage

// File: rtl/boot_cmd_tx.sv
module boot_cmd_tx
    import emmc_boot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic bit_out,
    output logic last
);
    localparam int IW = $clog2(FRAME_LEN + 1);

    logic [IW-1:0]      idx_q;
    logic [HDR_LEN-1:0] sh_q;
    logic [CRC_W-1:0]   crc_q;
    logic               in_hdr;
    logic               fb;

    assign in_hdr  = idx_q < IW'(HDR_LEN);
    assign bit_out = in_hdr ? sh_q[HDR_LEN-1] : crc_q[CRC_W-1];
    assign last    = go && (idx_q == IW'(FRAME_LEN - 1));
    assign fb      = sh_q[HDR_LEN-1] ^ crc_q[CRC_W-1];

    // Header bits leave first while the CRC accumulates; the CRC register
    // then shifts out and back-fills with ones, which yields the end bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            sh_q  <= BOOT_HDR;
            crc_q <= '0;
        end else if (!go) begin
            idx_q <= '0;
            sh_q  <= BOOT_HDR;
            crc_q <= '0;
        end else begin
            idx_q <= idx_q + IW'(1);
            if (in_hdr) begin
                sh_q  <= {sh_q[HDR_LEN-2:0], 1'b0};
                crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
            end else begin
                crc_q <= {crc_q[CRC_W-2:0], 1'b1};
            end
        end
    end

    AST_FRAME_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) |-> ($past(idx_q) == IW'(FRAME_LEN - 1))); // R3

endmodule

// File: rtl/boot_ack_det.sv
module boot_ack_det
    import emmc_boot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dat0,
    output logic ack_ok
);
    logic       armed_q;
    logic [1:0] cnt_q;
    logic [1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            bits_q  <= '0;
        end else if (!en) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            bits_q  <= '0;
        end else if (!armed_q) begin
            if (!dat0) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end
        end else begin
            bits_q <= {bits_q[0], dat0};
            if (cnt_q == 2'd2) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    assign ack_ok = en && armed_q && (cnt_q == 2'd2) && ({bits_q, dat0} == ACK_PAT);

    AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> $past(en)); // R5

endmodule

// File: rtl/boot_wdog.sv
module boot_wdog #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && (cnt_q != CW'(LIMIT)))
            cnt_q <= cnt_q + CW'(1);
    end

    assign expired = run && (cnt_q == CW'(LIMIT));

    AST_WDOG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(LIMIT) && !clear) |=> (cnt_q == CW'(LIMIT))); // R6

endmodule

// File: rtl/boot_stat_reg.sv
module boot_stat_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr) | set;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_W1C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]); // R10
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]); // R10
    end

endmodule

// File: rtl/emmc_boot_seq.sv
module emmc_boot_seq
    import emmc_boot_pkg::*;
#(
    parameter int unsigned INIT_CYC     = 74,
    parameter int unsigned ACK_TMO_CYC  = 10_000_000,
    parameter int unsigned DATA_TMO_CYC = 190_000_000,
    parameter int          BCW          = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              expect_ack,
    input  logic [BCW-1:0]    byte_count,
    input  logic [STAT_W-1:0] clr,
    input  logic              dat0,
    input  logic              blk_rcvd,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              rx_armed,
    output logic              busy,
    output logic              done,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    localparam int BLKW = BCW - BLK_LOG2;
    localparam int ICW  = $clog2(INIT_CYC + 1);

    boot_state_t       state_q, state_d;
    logic [ICW-1:0]    init_cnt_q;
    logic              ack_mode_q;
    logic [BLKW-1:0]   blk_tgt_q;
    logic [BLKW-1:0]   blk_cnt_q;
    logic              done_q;

    logic              count_ok;
    logic              accept;
    logic              tx_go, tx_bit, tx_last;
    logic              ack_ok;
    logic              ack_exp, dat_exp;
    logic              last_blk;
    logic [STAT_W-1:0] ev;

    assign count_ok = (byte_count[GRAN_LOG2-1:0] == '0) && (byte_count != '0);
    assign accept   = (state_q == S_IDLE) && start && count_ok;
    assign last_blk = blk_rcvd && (blk_cnt_q == blk_tgt_q - BLKW'(1));

    // ---------------- sub-blocks ----------------
    boot_cmd_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (tx_go),
        .bit_out (tx_bit),
        .last    (tx_last)
    );

    boot_ack_det u_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state_q == S_ACKW),
        .dat0   (dat0),
        .ack_ok (ack_ok)
    );

    boot_wdog #(.LIMIT(ACK_TMO_CYC)) u_ack_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q == S_IDLE) || (state_q == S_INIT)),
        .run     ((state_q == S_CMD) || (state_q == S_ACKW)),
        .expired (ack_exp)
    );

    boot_wdog #(.LIMIT(DATA_TMO_CYC)) u_dat_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != S_DATW),
        .run     ((state_q == S_DATW) && ack_mode_q),
        .expired (dat_exp)
    );

    boot_stat_reg #(.W(STAT_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev),
        .clr   (clr),
        .flags (status)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_INIT;
            S_INIT: if (init_cnt_q == ICW'(INIT_CYC - 1)) state_d = S_CMD;
            S_CMD:  if (tx_last) state_d = ack_mode_q ? S_ACKW : S_DATW;
            S_ACKW: begin
                if (ack_exp)     state_d = S_IDLE;
                else if (ack_ok) state_d = S_DATW;
            end
            S_DATW: begin
                if (dat_exp)   state_d = S_IDLE;
                else if (!dat0) state_d = S_RECV;
            end
            S_RECV: if (last_blk) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            init_cnt_q <= '0;
            ack_mode_q <= 1'b0;
            blk_tgt_q  <= '0;
            blk_cnt_q  <= '0;
            done_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            done_q     <= (state_q != S_IDLE) && (state_d == S_IDLE);
            init_cnt_q <= (state_q == S_INIT) ? init_cnt_q + ICW'(1) : '0;
            if (accept) begin
                ack_mode_q <= expect_ack;
                blk_tgt_q  <= byte_count[BCW-1:BLK_LOG2];
            end
            if (state_q != S_RECV)
                blk_cnt_q <= '0;
            else if (blk_rcvd)
                blk_cnt_q <= blk_cnt_q + BLKW'(1);
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        tx_go    = (state_q == S_CMD);
        cmd_oe   = tx_go;
        cmd_out  = tx_go ? tx_bit : 1'b1;
        busy     = (state_q != S_IDLE);
        rx_armed = (state_q == S_ACKW) || (state_q == S_DATW) || (state_q == S_RECV);
        done     = done_q;
        irq      = |status;
        ev                 = '0;
        ev[ST_CMD_DONE]    = (state_q == S_CMD) && tx_last;
        ev[ST_ACK]         = (state_q == S_ACKW) && !ack_exp && ack_ok;
        ev[ST_ACK_TMO]     = (state_q == S_ACKW) && ack_exp;
        ev[ST_DSTART]      = (state_q == S_DATW) && !dat_exp && !dat0;
        ev[ST_DAT_TMO]     = (state_q == S_DATW) && dat_exp;
        ev[ST_RX_DONE]     = (state_q == S_RECV) && last_blk;
    end

    // ---------------- assertions ----------------
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && start && !count_ok) |=> (state_q == S_IDLE)); // R1
    AST_INIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> (($past(state_q) == S_INIT) &&
                           ($past(init_cnt_q) == ICW'(INIT_CYC - 1)))); // R2
    AST_ACKW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACKW) |-> ack_mode_q); // R4
    AST_TMO_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_ACK_TMO]) |-> !$rose(status[ST_RX_DONE])); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_BLK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RECV) |-> (blk_cnt_q < blk_tgt_q)); // R9
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ack_mode_q)); // R12

endmodule

// File: tb/sim_emmc_boot_seq.sv
`timescale 1ns/1ps
module sim_emmc_boot_seq;
    localparam int INIT_CYC = 74;
    localparam int ACK_TMO  = 200;
    localparam int DATA_TMO = 300;
    localparam int BCW      = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, expect_ack = 1'b0, dat0 = 1'b1, blk_rcvd = 1'b0;
    logic [BCW-1:0] byte_count = '0;
    logic [5:0] clr = '0;
    logic cmd_out, cmd_oe, rx_armed, busy, done, irq;
    logic [5:0] status;

    int tests = 0, fails = 0, tcnt = 0;
    int seed_dummy;

    always #2.5 clk = ~clk;

    emmc_boot_seq #(.INIT_CYC(INIT_CYC), .ACK_TMO_CYC(ACK_TMO),
                    .DATA_TMO_CYC(DATA_TMO), .BCW(BCW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .expect_ack(expect_ack),
        .byte_count(byte_count), .clr(clr), .dat0(dat0), .blk_rcvd(blk_rcvd),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .rx_armed(rx_armed), .busy(busy),
        .done(done), .status(status), .irq(irq));

    function automatic logic [47:0] exp_frame();
        logic [39:0] h = {2'b01, 6'd0, 32'hFFFF_FFFA};
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic f = h[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (f) c = c ^ 7'b000_1001;
        end
        return {h, c, 1'b1};
    endfunction

    function automatic logic [5:0] exp_ok_stat(input logic ea);
        return {1'b1, 2'b00, 1'b1, ea, 1'b1};
    endfunction

    task automatic tick();
        @(negedge clk);
        tcnt++;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        clr = 6'h3F; tick(); clr = '0;
    endtask

    task automatic start_boot(input logic ea, input logic [BCW-1:0] bytes);
        start = 1'b1; expect_ack = ea; byte_count = bytes;
        tick();
        start = 1'b0;
    endtask

    task automatic take_frame(output int init_n, output logic [47:0] fr, output bit oe_ok);
        int guard = 0;
        init_n = 0; oe_ok = 1'b1; fr = '0;
        while (!cmd_oe && guard < 1000) begin
            if (busy) init_n++;
            tick(); guard++;
        end
        tcnt = 0;
        for (int i = 0; i < 48; i++) begin
            fr[47-i] = cmd_out;
            if (!cmd_oe) oe_ok = 1'b0;
            tick();
        end
        if (cmd_oe) oe_ok = 1'b0;
    endtask

    task automatic drive_dat(input logic [4:0] pat);
        for (int i = 4; i >= 0; i--) begin
            tick();
            dat0 = pat[i];
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 2000) begin tick(); guard++; end
    endtask

    task automatic run_blocks(input int n);
        for (int b = 0; b < n; b++) begin
            if (b == n - 1) chk(busy == 1'b1, "R9 busy before last block", busy, 1);
            blk_rcvd = 1'b1; tick(); blk_rcvd = 1'b0;
            if (b == n - 1) begin
                chk(done == 1'b1, "R9 done after last block", done, 1);
                chk(busy == 1'b0, "R9 idle after last block", busy, 0);
            end else begin
                repeat ($urandom % 2) tick();
            end
        end
    endtask

    task automatic data_start();
        dat0 = 1'b0; tick(); dat0 = 1'b1;
        chk(status[2] == 1'b1, "R8 data start flag", status[2], 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        logic [47:0] fr;
        bit oe_ok;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // reset state
        chk(status == 6'h00, "R10 reset status", status, 0);
        chk(busy == 1'b0 && cmd_oe == 1'b0 && cmd_out == 1'b1, "R2 reset lines",
            {busy, cmd_oe, cmd_out}, 3'b001);
        chk(irq == 1'b0, "R11 reset irq", irq, 0);

        // R1: rejected counts
        start_boot(1'b1, 32'd0); tick();
        chk(busy == 1'b0, "R1 zero count ignored", busy, 0);
        start_boot(1'b1, 32'd131072 + 32'd512); tick();
        chk(busy == 1'b0, "R1 non-multiple ignored", busy, 0);

        // ack timeout with a malformed pattern and a stray start (R5, R6, R12)
        start_boot(1'b1, 32'd131072);
        take_frame(n, fr, oe_ok);
        chk(n == INIT_CYC, "R2 init clocks", n, INIT_CYC);
        chk(fr == exp_frame(), "R3 frame bits", fr, exp_frame());
        chk(oe_ok, "R3 oe window", oe_ok, 1);
        chk(status[0] == 1'b1, "R4 cmd done flag", status[0], 1);
        drive_dat(5'b00111);
        start = 1'b1; expect_ack = 1'b0; tick(); start = 1'b0;
        wait_done();
        chk(tcnt == ACK_TMO + 1, "R6 ack timeout cycle", tcnt, ACK_TMO + 1);
        chk(status == 6'b001001, "R6 R12 timeout status", status, 6'b001001);
        chk(status[1] == 1'b0, "R5 bad pattern not ack", status[1], 0);
        chk(rx_armed == 1'b0, "R6 receive closed", rx_armed, 0);
        chk(irq == 1'b1, "R11 irq set", irq, 1);

        // W1C (R10, R11)
        clr = 6'b001000; tick(); clr = '0;
        chk(status == 6'b000001, "R10 partial clear", status, 1);
        clr = 6'b000001; tick(); clr = '0;
        chk(status == 6'h00, "R10 full clear", status, 0);
        chk(irq == 1'b0, "R11 irq clear", irq, 0);

        // data timeout after ack (R5, R7)
        start_boot(1'b1, 32'd131072);
        take_frame(n, fr, oe_ok);
        repeat (3) tick();
        drive_dat(5'b00101);
        chk(status[1] == 1'b1, "R5 ack flag", status[1], 1);
        tcnt = 0;
        wait_done();
        chk(tcnt == DATA_TMO + 1, "R7 data timeout cycle", tcnt, DATA_TMO + 1);
        chk(status == 6'b010011, "R7 data timeout status", status, 6'b010011);
        clear_all();

        // no-ack mode waits unbounded (R4)
        start_boot(1'b0, 32'd131072);
        take_frame(n, fr, oe_ok);
        repeat (400) tick();
        chk(busy == 1'b1 && rx_armed == 1'b1, "R4 unbounded wait", {busy, rx_armed}, 2'b11);
        chk(status == 6'b000001, "R4 only cmd done", status, 1);
        data_start();
        run_blocks(256);
        chk(status == exp_ok_stat(1'b0), "R9 no-ack boot status", status, exp_ok_stat(1'b0));
        clear_all();

        // randomized full boots
        for (int it = 0; it < 6; it++) begin
            logic ea = 1'($urandom % 2);
            int mult = 1 + int'($urandom % 2);
            start_boot(ea, BCW'(mult) << 17);
            take_frame(n, fr, oe_ok);
            chk(fr == exp_frame() && oe_ok, "R3 random frame", fr, exp_frame());
            chk(n == INIT_CYC, "R2 random init", n, INIT_CYC);
            if (ea) begin
                repeat ($urandom % 20) tick();
                drive_dat(5'b00101);
            end
            blk_rcvd = 1'b1; tick(); blk_rcvd = 1'b0;
            repeat ($urandom % 30) tick();
            data_start();
            run_blocks(mult * 256);
            chk(status == exp_ok_stat(ea), "R9 random boot status", status, exp_ok_stat(ea));
            clear_all();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule